// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the integer multiply/divide engine of a processor core. It owns the two architectural product registers, HI and LO, and performs signed and unsigned multiply, signed and unsigned divide, multiply-accumulate and multiply-subtract on the combined HI:LO pair. It also handles moves between general registers and HI/LO, and a 32-bit multiply whose low word is returned on the result port.

The requester presents an operation group bit, a six-bit function code and two operands together with a start strobe. Every operation except divide takes effect on the clock edge that accepts it. Divide is iterative at one quotient bit per cycle and raises `busy` for exactly `W` cycles. The unit accepts nothing while `busy` is high, so a requester that wants a value from HI or LO keeps its strobe asserted until the divide has finished. Results that go to a general register appear on `res` with `res_valid` high for one cycle.

Top module: `mdu_hilo_unit`

## Requirements
- R1: After synchronous reset HI and LO read as zero, and `busy` and `res_valid` are low.
- R2: With `grp`=0, code 0x11 copies `rs_val` into HI and 0x13 copies it into LO. Code 0x10 returns HI and 0x12 returns LO on `res`, with `res_valid` high in the cycle after the accepting edge.
- R3: With `grp`=0, code 0x18 (signed) and 0x19 (unsigned) multiply `rs_val` by `rt_val`. The upper W product bits go to HI and the lower W bits to LO, and both can be read by the next operation.
- R4: With `grp`=0, code 0x1A (signed) and 0x1B (unsigned) divide `rs_val` by `rt_val`. The quotient goes to LO and the remainder to HI. Signed division truncates toward zero and the remainder takes the sign of the dividend. The most negative value divided by -1 gives a quotient equal to the most negative value and a remainder of zero.
- R5: `busy` rises on the edge that accepts a divide and stays high for exactly W cycles. HI and LO take the divide result on the edge where `busy` falls.
- R6: A divide by zero finishes in the same W cycles as any other divide. Its HI/LO contents are defined but are not specified.
- R7: With `grp`=1, code 0x00 (signed) and 0x01 (unsigned) add the 2W-bit product to the 2W-bit value {HI, LO}, with carry between the halves, and write the sum back split into HI and LO.
- R8: With `grp`=1, code 0x04 (signed) and 0x05 (unsigned) subtract the 2W-bit product from {HI, LO}, with borrow between the halves, and write the difference back.
- R9: With `grp`=1, code 0x02 returns the low W bits of the product on `res` in the cycle after the accepting edge and leaves HI and LO unchanged.
- R10: A start strobe seen while `busy` is high is not accepted and changes nothing. A move-from strobe that is held through a divide returns that divide's result.
- R11: Function codes not listed above change neither HI nor LO and produce no `res_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation request strobe; accepted when `busy` is low |
| grp | input | 1 | Operation group: 0 primary, 1 secondary |
| func | input | 6 | Function code within the group |
| rs_val | input | W | First operand (multiplicand, dividend, move source) |
| rt_val | input | W | Second operand (multiplier, divisor) |
| busy | output | 1 | Divide in progress; requests are not accepted |
| res_valid | output | 1 | `res` carries a new result this cycle |
| res | output | W | Result returned to a general register |

## Verification
The bench builds the unit with W=5, which makes every operand pair (1024 of them) reachable for each operation. The sweep therefore covers every divisor including zero, the most-negative-by-minus-one divide (-16 / -1) and every sign combination of the multiply, accumulate and subtract forms. Each result is compared with integer arithmetic that the bench does itself. Directed sequences then test a start strobe dropped during a divide and a move-from held through one.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    // Operation classes carried from decode into the datapath
    typedef enum logic [3:0] {
        K_NONE,
        K_MFHI,
        K_MTHI,
        K_MFLO,
        K_MTLO,
        K_MUL,
        K_DIV,
        K_MAC,
        K_MSB,
        K_MUL32
    } mdu_kind_e;

    typedef struct packed {
        mdu_kind_e kind;
        logic      sgn;
    } mdu_op_t;

    // Primary group codes
    localparam logic [5:0] FN_FROM_HI = 6'h10;
    localparam logic [5:0] FN_TO_HI   = 6'h11;
    localparam logic [5:0] FN_FROM_LO = 6'h12;
    localparam logic [5:0] FN_TO_LO   = 6'h13;
    localparam logic [5:0] FN_MUL_S   = 6'h18;
    localparam logic [5:0] FN_MUL_U   = 6'h19;
    localparam logic [5:0] FN_DIV_S   = 6'h1A;
    localparam logic [5:0] FN_DIV_U   = 6'h1B;
    // Secondary group codes
    localparam logic [5:0] FN_MAC_S   = 6'h00;
    localparam logic [5:0] FN_MAC_U   = 6'h01;
    localparam logic [5:0] FN_MUL_LOW = 6'h02;
    localparam logic [5:0] FN_MSB_S   = 6'h04;
    localparam logic [5:0] FN_MSB_U   = 6'h05;

    function automatic mdu_op_t mdu_decode(input logic grp, input logic [5:0] fn);
        mdu_op_t o;
        o.kind = K_NONE;
        o.sgn  = 1'b0;
        if (!grp) begin
            unique case (fn)
                FN_FROM_HI: o.kind = K_MFHI;
                FN_TO_HI:   o.kind = K_MTHI;
                FN_FROM_LO: o.kind = K_MFLO;
                FN_TO_LO:   o.kind = K_MTLO;
                FN_MUL_S:   begin o.kind = K_MUL; o.sgn = 1'b1; end
                FN_MUL_U:   o.kind = K_MUL;
                FN_DIV_S:   begin o.kind = K_DIV; o.sgn = 1'b1; end
                FN_DIV_U:   o.kind = K_DIV;
                default:    o.kind = K_NONE;
            endcase
        end else begin
            unique case (fn)
                FN_MAC_S:   begin o.kind = K_MAC; o.sgn = 1'b1; end
                FN_MAC_U:   o.kind = K_MAC;
                FN_MUL_LOW: begin o.kind = K_MUL32; o.sgn = 1'b1; end
                FN_MSB_S:   begin o.kind = K_MSB; o.sgn = 1'b1; end
                FN_MSB_U:   o.kind = K_MSB;
                default:    o.kind = K_NONE;
            endcase
        end
        return o;
    endfunction

endpackage

// File: rtl/mdu_decoder.sv
module mdu_decoder
    import mdu_pkg::*;
(
    input  logic       grp,
    input  logic [5:0] func,
    output mdu_op_t    op
);
    assign op = mdu_decode(grp, func);
endmodule

// File: rtl/mdu_product.sv
// Full-width product with optional accumulate or subtract on {HI, LO}
module mdu_product
    import mdu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           sgn,
    input  mdu_kind_e      kind,
    input  logic [2*W-1:0] acc,
    output logic [2*W-1:0] full
);
    localparam int PW = 2 * W;

    logic [PW-1:0] ax, bx, prod;

    // Extending both operands to 2W bits makes the low 2W bits of the
    // product correct for either signedness.
    always_comb begin
        ax   = sgn ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
        bx   = sgn ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
        prod = ax * bx;
        unique case (kind)
            K_MAC:   full = acc + prod;
            K_MSB:   full = acc - prod;
            default: full = prod;
        endcase
    end
endmodule

// File: rtl/mdu_divider.sv
// Restoring divider, one quotient bit per cycle, sign fix-up on the last step
module mdu_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic         sgn,
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] dvs,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  rem_q, quo_q, dvs_q;
    logic          neg_q_q, neg_r_q;

    logic [W:0]    shifted, diff;
    logic          fits;
    logic [W-1:0]  rem_n, quo_n;
    logic [W-1:0]  dvd_mag, dvs_mag;

    always_comb begin
        dvd_mag = (sgn && dvd[W-1]) ? -dvd : dvd;
        dvs_mag = (sgn && dvs[W-1]) ? -dvs : dvs;
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, dvs_q};
        fits    = ~diff[W];
        rem_n   = fits ? diff[W-1:0] : shifted[W-1:0];
        quo_n   = {quo_q[W-2:0], fits};
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));
    assign quo  = neg_q_q ? -quo_n : quo_n;
    assign rem  = neg_r_q ? -rem_n : rem_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            rem_q   <= '0;
            quo_q   <= '0;
            dvs_q   <= '0;
            neg_q_q <= 1'b0;
            neg_r_q <= 1'b0;
        end else if (go && !busy) begin
            cnt_q   <= CW'(W);
            rem_q   <= '0;
            quo_q   <= dvd_mag;
            dvs_q   <= dvs_mag;
            neg_q_q <= sgn & (dvd[W-1] ^ dvs[W-1]);
            neg_r_q <= sgn & dvd[W-1];
        end else if (busy) begin
            cnt_q <= cnt_q - CW'(1);
            rem_q <= rem_n;
            quo_q <= quo_n;
        end
    end
endmodule

// File: rtl/mdu_hilo_unit.sv
module mdu_hilo_unit
    import mdu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         grp,
    input  logic [5:0]   func,
    input  logic [W-1:0] rs_val,
    input  logic [W-1:0] rt_val,
    output logic         busy,
    output logic         res_valid,
    output logic [W-1:0] res
);
    localparam int PW = 2 * W;

    logic [W-1:0]  hi_q, lo_q;
    mdu_op_t       op;
    logic          accept, div_go, div_done;
    logic [W-1:0]  div_quo, div_rem;
    logic [PW-1:0] prod;

    mdu_decoder u_dec (
        .grp  (grp),
        .func (func),
        .op   (op)
    );

    mdu_product #(.W(W)) u_prod (
        .a    (rs_val),
        .b    (rt_val),
        .sgn  (op.sgn),
        .kind (op.kind),
        .acc  ({hi_q, lo_q}),
        .full (prod)
    );

    mdu_divider #(.W(W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .sgn  (op.sgn),
        .dvd  (rs_val),
        .dvs  (rt_val),
        .busy (busy),
        .done (div_done),
        .quo  (div_quo),
        .rem  (div_rem)
    );

    assign accept = start & ~busy;
    assign div_go = accept & (op.kind == K_DIV);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q      <= '0;
            lo_q      <= '0;
            res       <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (div_done) begin
                hi_q <= div_rem;
                lo_q <= div_quo;
            end else if (accept) begin
                unique case (op.kind)
                    K_MFHI: begin res <= hi_q; res_valid <= 1'b1; end
                    K_MFLO: begin res <= lo_q; res_valid <= 1'b1; end
                    K_MTHI: hi_q <= rs_val;
                    K_MTLO: lo_q <= rs_val;
                    K_MUL, K_MAC, K_MSB: {hi_q, lo_q} <= prod;
                    K_MUL32: begin res <= prod[W-1:0]; res_valid <= 1'b1; end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdu_hilo_unit_chk.sv
module mdu_hilo_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         res_valid,
    input logic         div_go,
    input logic [W-1:0] hi_q,
    input logic [W-1:0] lo_q
);
    localparam int RW = $clog2(W + 2) + 1;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)       run_q <= '0;
        else if (busy) run_q <= run_q + RW'(1);
        else           run_q <= '0;
    end

    // R5: an accepted divide raises busy on the next cycle
    a_r5_busy_rise: assert property (@(posedge clk) disable iff (rst)
        div_go |=> busy);

    // R5, R6: busy never lasts beyond W cycles
    a_r6_no_hang: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_q < RW'(W)));

    // R5: busy falls after exactly W cycles
    a_r5_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_q == RW'(W)));

    // R10: nothing touches HI/LO while a divide is running
    a_r10_hilo_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(hi_q) && $stable(lo_q)));

    // R10: a strobe during busy yields no result
    a_r10_no_result: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> !res_valid);

    // R2: a result only follows an accepted request
    a_r2_valid_src: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(start && !busy));
endmodule

bind mdu_hilo_unit mdu_hilo_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .res_valid (res_valid),
    .div_go    (div_go),
    .hi_q      (hi_q),
    .lo_q      (lo_q)
);

// File: tb/mdu_hilo_unit_tb.sv
`timescale 1ns/1ps
module mdu_hilo_unit_tb;
    localparam int W = 5;
    localparam longint M  = (64'd1 << W) - 1;
    localparam longint M2 = (64'd1 << (2 * W)) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         grp = 1'b0;
    logic [5:0]   func = '0;
    logic [W-1:0] rs_val = '0;
    logic [W-1:0] rt_val = '0;
    logic         busy, res_valid;
    logic [W-1:0] res;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mdu_hilo_unit #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .grp(grp), .func(func),
        .rs_val(rs_val), .rt_val(rt_val),
        .busy(busy), .res_valid(res_valid), .res(res)
    );

    function automatic longint sx(input logic [W-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present one request for one cycle; returns at the negedge after the accepting edge
    task automatic issue(input logic g, input logic [5:0] f,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        grp = g; func = f; rs_val = a; rt_val = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic read_reg(input logic [5:0] f, output longint v, output logic vld);
        issue(1'b0, f, '0, '0);
        v = longint'(res);
        vld = res_valid;
    endtask

    task automatic load_hilo(input longint h, input longint l);
        issue(1'b0, 6'h11, W'(h), '0);
        issue(1'b0, 6'h13, W'(l), '0);
    endtask

    task automatic check_hilo(input string tag, input longint eh, input longint el);
        longint v;
        logic   vld;
        read_reg(6'h10, v, vld);
        chk({tag, " HI"}, v, eh);
        read_reg(6'h12, v, vld);
        chk({tag, " LO"}, v, el);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(8 * 190000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        longint v, p, acc, e, q, r, h, l;
        logic   vld;
        int     n;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 busy", longint'(busy), 0);
        chk("R1 res_valid", longint'(res_valid), 0);
        check_hilo("R1", 0, 0);

        // R2: move-to / move-from
        issue(1'b0, 6'h11, 5'h15, '0);
        issue(1'b0, 6'h13, 5'h0A, '0);
        read_reg(6'h10, v, vld);
        chk("R2 mfhi value", v, 5'h15);
        chk("R2 mfhi valid", longint'(vld), 1);
        read_reg(6'h12, v, vld);
        chk("R2 mflo value", v, 5'h0A);
        @(negedge clk);
        chk("R2 valid one cycle", longint'(res_valid), 0);

        // R3: signed and unsigned multiply, exhaustive
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a <= M; a++) begin
                for (int b = 0; b <= M; b++) begin
                    issue(1'b0, s ? 6'h18 : 6'h19, W'(a), W'(b));
                    p = s ? sx(W'(a)) * sx(W'(b)) : longint'(a) * longint'(b);
                    p = p & M2;
                    check_hilo("R3 mult", (p >> W) & M, p & M);
                end
            end
        end

        // R7, R8: accumulate and subtract on HI:LO, exhaustive operands
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a <= M; a++) begin
                for (int b = 0; b <= M; b++) begin
                    h = (a * 3 + b) & M;
                    l = (b * 5 + a + 1) & M;
                    load_hilo(h, l);
                    p = (m[0] == 1'b0) ? sx(W'(a)) * sx(W'(b))
                                       : longint'(a) * longint'(b);
                    acc = (h << W) | l;
                    if (m < 2) begin
                        issue(1'b1, (m == 0) ? 6'h00 : 6'h01, W'(a), W'(b));
                        e = (acc + p) & M2;
                        check_hilo("R7 madd", (e >> W) & M, e & M);
                    end else begin
                        issue(1'b1, (m == 2) ? 6'h04 : 6'h05, W'(a), W'(b));
                        e = (acc - p) & M2;
                        check_hilo("R8 msub", (e >> W) & M, e & M);
                    end
                end
            end
        end

        // R9: low-word multiply to res
        load_hilo(5'h03, 5'h1C);
        for (int a = 0; a <= M; a++) begin
            for (int b = 0; b <= M; b++) begin
                issue(1'b1, 6'h02, W'(a), W'(b));
                chk("R9 valid", longint'(res_valid), 1);
                chk("R9 low word", longint'(res), (longint'(a) * longint'(b)) & M);
            end
        end
        check_hilo("R9 hilo untouched", 5'h03, 5'h1C);

        // R4, R5, R6: divide, exhaustive including zero divisors
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a <= M; a++) begin
                for (int b = 0; b <= M; b++) begin
                    issue(1'b0, s ? 6'h1A : 6'h1B, W'(a), W'(b));
                    wait_idle(n);
                    if (b == 0) begin
                        chk("R6 div0 cycles", n, W);
                    end else begin
                        chk("R5 busy cycles", n, W);
                        if (s == 1) begin
                            q = sx(W'(a)) / sx(W'(b));
                            r = sx(W'(a)) % sx(W'(b));
                        end else begin
                            q = longint'(a) / longint'(b);
                            r = longint'(a) % longint'(b);
                        end
                        check_hilo("R4 div", r & M, q & M);
                    end
                end
            end
        end

        // R4: most negative divided by -1, named case
        issue(1'b0, 6'h1A, 5'h10, 5'h1F);
        wait_idle(n);
        check_hilo("R4 minneg/-1", 0, 5'h10);

        // R10: a one-cycle strobe during busy is dropped
        issue(1'b0, 6'h1B, 5'd13, 5'd4);
        chk("R5 busy after accept", longint'(busy), 1);
        issue(1'b0, 6'h11, 5'd22, '0);
        wait_idle(n);
        check_hilo("R10 dropped strobe", 1, 3);

        // R10: move-from held through a divide returns the divide result
        issue(1'b0, 6'h1B, 5'd29, 5'd5);
        @(negedge clk);
        grp = 1'b0; func = 6'h10; start = 1'b1;
        n = 0;
        while (!res_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk("R10 held mfhi", longint'(res), 4);
        chk("R10 held wait", n, W);

        // R11: unassigned codes
        load_hilo(5'h09, 5'h11);
        issue(1'b0, 6'h14, 5'h1F, 5'h1F);
        chk("R11 no valid p", longint'(res_valid), 0);
        issue(1'b1, 6'h03, 5'h1F, 5'h1F);
        chk("R11 no valid s", longint'(res_valid), 0);
        issue(1'b1, 6'h18, 5'h1F, 5'h1F);
        chk("R11 no valid x", longint'(res_valid), 0);
        check_hilo("R11 unchanged", 5'h09, 5'h11);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule